// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block supplies the word address for every beat of a four-beat burst into a synchronous memory. A burst is opened by either of two address strobes. One comes from the processor and the other from the cache controller. On the clock edge that samples either strobe, the block captures the external address and the ordering mode. From then on, the two least significant address bits step through a four-beat sequence on each cycle that the advance input is sampled high. The upper address bits never change inside a burst.

Two orderings are supported. In linear order the low bits are the starting bits plus the beat count, modulo four. In interleaved order the low bits are the starting bits XOR the beat count. The block reports the full current address, the beat index, and which strobe opened the current burst. All inputs are sampled on the rising clock edge, and the outputs come from registers updated on that edge.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_n is sampled low at a rising edge, the next state has addr_out = 0, beat_idx = 0 and src_ctrl = 0, and interleaved order is selected.
- R2: An edge that samples proc_strobe = 1 loads addr_in. After that edge, addr_out equals the sampled addr_in and beat_idx = 0.
- R3: An edge that samples ctrl_strobe = 1 with proc_strobe = 0 loads addr_in in the same way, and after that edge src_ctrl = 1.
- R4: An edge that samples both strobes high is treated as a processor load, and after that edge src_ctrl = 0.
- R5: An edge that samples advance = 1 with no strobe raises beat_idx by one, modulo 4 (3 wraps to 0).
- R6: An edge that samples advance = 0 with no strobe leaves addr_out and beat_idx unchanged, so wait states can be inserted.
- R7: When order_sel = 0 is captured at load, addr_out[1:0] = (start[1:0] + beat_idx) mod 4. A start of 2 gives 2,3,0,1.
- R8: When order_sel = 1 is captured at load, addr_out[1:0] = start[1:0] XOR beat_idx. A start of 1 gives 1,0,3,2, and a start of 2 gives 2,3,0,1.
- R9: order_sel is sampled only on a loading edge. Changing it during a burst has no effect on addr_out.
- R10: addr_out[16:2] stays equal to the loaded addr_in[16:2] for the whole burst, including after the wrap past the fourth beat. No carry enters the upper bits.
- R11: A strobe during a burst restarts the sequence from the newly loaded address with beat_idx = 0. This applies even when advance is high on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| proc_strobe | input | 1 | Processor address strobe, active high |
| ctrl_strobe | input | 1 | Cache-controller address strobe, active high |
| addr_in | input | 17 | External starting address |
| advance | input | 1 | Step to the next beat when high |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order |
| addr_out | output | 17 | Current burst word address |
| beat_idx | output | 2 | Beats advanced since the load |
| src_ctrl | output | 1 | 1 when the current burst was opened by the cache-controller strobe |

## Verification
The bench targets four corner cases:
- **Wrap past the fourth beat.** The test starts at an address with all upper bits set. A design that carries into the upper bits would show a changed upper field on the fifth beat.
- **Both strobes together.** A design with the wrong priority would report the cache controller as the source.
- **Strobe and advance on the same edge.** A design that lets advance win would begin the new burst at beat one instead of beat zero.
- **Mode flip mid-burst.** A design that samples the mode every cycle would switch sequence halfway through.

A long stretch of random strobes, advances and mode changes is also compared cycle by cycle against a behavioural model. This catches mistakes in the hold and reload paths.

// File: rtl/burst_pkg.sv
// Shared types for the burst address sequence generator.
// Assumes: one burst ordering bit and one source bit are enough.
package burst_pkg;

    // Low-bit sequencing rule for a burst.
    typedef enum logic [0:0] {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    // Which strobe opened the current burst.
    typedef enum logic [0:0] {
        SRC_PROC = 1'b0,
        SRC_CTRL = 1'b1
    } src_e;

endpackage

// File: rtl/burst_load_arb.sv
// Combines the two address strobes into one load request and picks the source.
// Assumes: both strobes are sampled by the caller's registers on the same edge;
// the processor strobe has priority when both are high.
module burst_load_arb
    import burst_pkg::*;
(
    input  logic proc_strobe_i,
    input  logic ctrl_strobe_i,
    output logic load_o,
    output src_e src_o
);

    // Load on either strobe; processor wins a tie.
    always_comb begin
        load_o = proc_strobe_i | ctrl_strobe_i;
        src_o  = proc_strobe_i ? SRC_PROC : SRC_CTRL;
    end

endmodule

// File: rtl/burst_beat_ctr.sv
// Beat counter for one burst: cleared by a load, stepped by advance, wraps.
// Assumes: load has priority over advance; width BEAT_W sets beats per burst.
module burst_beat_ctr #(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              adv_i,
    output logic [BEAT_W-1:0] beat_o
);

    localparam logic [BEAT_W-1:0] BEAT_ONE = BEAT_W'(1);

    logic [BEAT_W-1:0] beat_q;

    // Clear on reset or load, step modulo 2**BEAT_W on advance, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else if (load_i) begin
            beat_q <= '0;
        end else if (adv_i) begin
            beat_q <= beat_q + BEAT_ONE;
        end
    end

    assign beat_o = beat_q;

    assert_beat_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i) |=> ((beat_q - $past(beat_q)) == BEAT_ONE));

    assert_beat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !load_i) |=> $stable(beat_q));

    assert_beat_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (beat_q == '0));

endmodule

// File: rtl/burst_order_map.sv
// Maps a starting low-address field and a beat count to the current low bits.
// Linear order is a ripple add (generated per bit), interleaved order is a XOR.
// Assumes: inputs are registered upstream; the result is purely combinational.
module burst_order_map
    import burst_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] start_i,
    input  logic [BEAT_W-1:0] beat_i,
    input  order_e            order_i,
    output logic [BEAT_W-1:0] lo_o
);

    logic [BEAT_W-1:0] lin_sum;
    logic [BEAT_W-1:0] ilv_val;
    logic [BEAT_W:0]   carry;

    assign carry[0] = 1'b0;

    // One full-adder stage and one XOR stage per low-address bit.
    for (genvar i = 0; i < BEAT_W; i++) begin : g_bit
        assign lin_sum[i]  = start_i[i] ^ beat_i[i] ^ carry[i];
        assign carry[i+1]  = (start_i[i] & beat_i[i]) | (carry[i] & (start_i[i] ^ beat_i[i]));
        assign ilv_val[i]  = start_i[i] ^ beat_i[i];
    end

    // Select the sequence picked at load time; the carry out is dropped (wrap).
    always_comb begin
        lo_o = (order_i == ORD_LINEAR) ? lin_sum : ilv_val;
    end

    // On the first beat both orderings must return the starting bits.
    always_comb begin
        if (!$isunknown({start_i, beat_i}) && beat_i == '0) begin
            assert_first_beat_R7: assert (lo_o == start_i);
        end
    end

endmodule

// File: rtl/burst_addr_seq.sv
// Top of the burst address sequence generator.
// Captures the address, mode and source on a strobe edge, then walks the low
// BEAT_W address bits under the advance input. Upper bits are frozen per burst.
// Assumes: synchronous active-low reset, single rising-edge clock.
module burst_addr_seq
    import burst_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              proc_strobe,
    input  logic              ctrl_strobe,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              advance,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] addr_out,
    output logic [BEAT_W-1:0] beat_idx,
    output logic              src_ctrl
);

    localparam int HI_W = ADDR_W - BEAT_W;

    logic              load;
    src_e              src_sel;
    logic [HI_W-1:0]   hi_q;
    logic [BEAT_W-1:0] lo_q;
    order_e            ord_q;
    src_e              src_q;
    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] lo_cur;

    burst_load_arb u_arb (
        .proc_strobe_i (proc_strobe),
        .ctrl_strobe_i (ctrl_strobe),
        .load_o        (load),
        .src_o         (src_sel)
    );

    // Capture address, mode and source on a load; hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q  <= '0;
            lo_q  <= '0;
            ord_q <= ORD_INTERLEAVE;
            src_q <= SRC_PROC;
        end else if (load) begin
            hi_q  <= addr_in[ADDR_W-1:BEAT_W];
            lo_q  <= addr_in[BEAT_W-1:0];
            ord_q <= order_e'(order_sel);
            src_q <= src_sel;
        end
    end

    burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .adv_i  (advance),
        .beat_o (beat_q)
    );

    burst_order_map #(.BEAT_W(BEAT_W)) u_map (
        .start_i (lo_q),
        .beat_i  (beat_q),
        .order_i (ord_q),
        .lo_o    (lo_cur)
    );

    // Drive outputs from the captured state.
    always_comb begin
        addr_out = {hi_q, lo_cur};
        beat_idx = beat_q;
        src_ctrl = (src_q == SRC_CTRL);
    end

    assert_load_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (addr_out == $past(addr_in)));

    assert_ctrl_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_strobe && !proc_strobe) |=> src_ctrl);

    assert_proc_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        proc_strobe |=> !src_ctrl);

    assert_hold_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !advance) |=> $stable(addr_out));

    assert_order_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(ord_q));

    assert_upper_fixed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(addr_out[ADDR_W-1:BEAT_W]));

endmodule

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        proc_strobe = 1'b0;
    logic        ctrl_strobe = 1'b0;
    logic [16:0] addr_in = '0;
    logic        advance = 1'b0;
    logic        order_sel = 1'b0;
    logic [16:0] addr_out;
    logic [1:0]  beat_idx;
    logic        src_ctrl;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit model_on = 0;
    string cur_tag = "R1";

    // behavioural reference state
    int m_base = 0;
    int m_beat = 0;
    int m_ilv  = 1;
    int m_src  = 0;

    always #4 clk = ~clk;

    burst_addr_seq dut (
        .clk(clk), .rst_n(rst_n), .proc_strobe(proc_strobe), .ctrl_strobe(ctrl_strobe),
        .addr_in(addr_in), .advance(advance), .order_sel(order_sel),
        .addr_out(addr_out), .beat_idx(beat_idx), .src_ctrl(src_ctrl)
    );

    function automatic int exp_addr();
        int lo;
        lo = m_base % 4;
        if (m_ilv != 0) lo = lo ^ m_beat;
        else            lo = (lo + m_beat) % 4;
        return (m_base - (m_base % 4)) + lo;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // reference model, updated on each rising edge from the sampled inputs
    always @(posedge clk) begin
        if (!rst_n) begin
            m_base <= 0; m_beat <= 0; m_ilv <= 1; m_src <= 0;
        end else if (proc_strobe || ctrl_strobe) begin
            m_base <= int'(addr_in);
            m_beat <= 0;
            m_ilv  <= order_sel ? 1 : 0;
            m_src  <= proc_strobe ? 0 : 1;
        end else if (advance) begin
            m_beat <= (m_beat + 1) % 4;
        end
        model_on <= 1'b1;
    end

    // compare against the model away from the active edge
    always @(negedge clk) begin
        if (model_on && !done) begin
            check({cur_tag, " addr"}, int'(addr_out), exp_addr());
            check({cur_tag, " beat"}, int'(beat_idx), m_beat);
            check({cur_tag, " src"},  int'(src_ctrl), m_src);
        end
    end

    task automatic cyc(input logic p, input logic c, input logic [16:0] a,
                       input logic adv, input logic ord);
        proc_strobe = p; ctrl_strobe = c; addr_in = a; advance = adv; order_sel = ord;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 addr", int'(addr_out), 0);
        check("R1 beat", int'(beat_idx), 0);
        check("R1 src",  int'(src_ctrl), 0);
        rst_n = 1'b1;

        // R2 / R7: processor load, linear, start 2 -> 2,3,0,1
        cur_tag = "R7";
        cyc(1, 0, 17'h0ABC6, 0, 0);
        check("R2 load addr", int'(addr_out), 'h0ABC6);
        check("R2 beat zero", int'(beat_idx), 0);
        cyc(0, 0, 17'h00000, 1, 1);
        check("R7 beat1", int'(addr_out[1:0]), 3);
        cyc(0, 0, 17'h00000, 1, 1);
        check("R7 beat2", int'(addr_out[1:0]), 0);
        cyc(0, 0, 17'h00000, 1, 1);
        check("R7 beat3", int'(addr_out[1:0]), 1);
        check("R5 beat index 3", int'(beat_idx), 3);
        cyc(0, 0, 17'h00000, 1, 1);
        check("R5 wrap beat", int'(beat_idx), 0);
        check("R10 wrap upper", int'(addr_out), 'h0ABC6);

        // R3 / R8 / R9: controller load, interleaved, start 1 -> 1,0,3,2, mode flipped mid-burst
        cur_tag = "R8";
        cyc(0, 1, 17'h1FFFD, 0, 1);
        check("R3 src ctrl", int'(src_ctrl), 1);
        check("R3 load addr", int'(addr_out), 'h1FFFD);
        cyc(0, 0, 17'h00000, 1, 0);
        check("R9 mode flip ignored beat1", int'(addr_out[1:0]), 0);
        cyc(0, 0, 17'h00000, 1, 0);
        check("R8 beat2", int'(addr_out[1:0]), 3);
        cyc(0, 0, 17'h00000, 1, 1);
        check("R8 beat3", int'(addr_out[1:0]), 2);
        check("R10 upper fixed", int'(addr_out[16:2]), 'h7FFF);

        // R6: wait states hold everything
        cur_tag = "R6";
        repeat (3) cyc(0, 0, 17'h15555, 0, 0);
        check("R6 hold addr", int'(addr_out), 'h1FFFE);
        check("R6 hold beat", int'(beat_idx), 3);

        // R4: both strobes, processor wins
        cur_tag = "R4";
        cyc(1, 1, 17'h00102, 0, 1);
        check("R4 src proc", int'(src_ctrl), 0);
        check("R4 addr", int'(addr_out), 'h00102);
        cyc(0, 0, 17'h00000, 1, 1);
        check("R8 start2 beat1", int'(addr_out[1:0]), 3);

        // R11: strobe together with advance restarts at beat 0
        cur_tag = "R11";
        cyc(0, 1, 17'h1FFFF, 1, 0);
        check("R11 restart beat", int'(beat_idx), 0);
        check("R11 restart addr", int'(addr_out), 'h1FFFF);
        // R10: linear start 3 at top of space: 3,0,1,2 and no carry
        cyc(0, 0, 17'h00000, 1, 0);
        check("R10 no carry", int'(addr_out), 'h1FFFC);
        cyc(0, 0, 17'h00000, 1, 0);
        check("R10 beat2", int'(addr_out), 'h1FFFD);
        cyc(0, 0, 17'h00000, 1, 0);
        check("R10 beat3", int'(addr_out), 'h1FFFE);

        // R5: random traffic against the model
        cur_tag = "R5";
        for (int i = 0; i < 400; i++) begin
            cyc(($urandom % 8) == 0, ($urandom % 6) == 0, 17'($urandom),
                ($urandom % 3) != 0, 1'($urandom));
        end

        // R1: reset mid-burst returns to the reset state
        cur_tag = "R1";
        cyc(0, 1, 17'h0F0F3, 0, 0);
        rst_n = 1'b0;
        cyc(0, 0, 17'h00000, 1, 0);
        check("R1 reset again addr", int'(addr_out), 0);
        check("R1 reset again src", int'(src_ctrl), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule